// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions on a two-wire MDC/MDIO pair. It reads or writes 16-bit PHY registers, and it can also hunt for the first PHY that answers on the bus. A caller presents a command for one cycle while the block is idle. The command is one of read, write or scan, and it comes with a 5-bit PHY address, a 5-bit register address and 16-bit write data. The block then shifts out a 64-bit frame, one bit per MDC period, and signals completion with a single-cycle pulse. Read data, an error flag and the discovered PHY address stay on the outputs until the next completion.

MDIO is split into an output value, an output enable and an input, so a pad or tristate buffer can be attached outside the block. The pad can be driven two ways, chosen by parameter. In push-pull mode the block drives both levels. In open-drain mode it drives only zeros, and it lets an external pull-up produce ones.

MDC is built from the system clock. Each frame bit lasts three phases of `PHASE_CYC` system cycles each. The default value gives an MDC period of at least 400 ns with a 125 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `mdc` is 0 and `mdioOe` is 0. Reset clears `done`, `rdData`, `error` and `foundPhy` to 0.
- R2: Every frame sends 64 bits in this order: 32 ones; the start pair 0,1; the opcode pair (1,0 for read, 0,1 for write); the PHY address, 5 bits MSB first; the register address, 5 bits MSB first. All of these bits are driven.
- R3: On a write, the turnaround pair 1,0 is driven after the register address, followed by the 16 write-data bits MSB first. MDIO is released after the frame.
- R4: On a read, MDIO is released for the 2 turnaround bits and the 16 data bits. `mdioIn` is sampled at the last system cycle of each data bit's MDC-high phase, MSB first. The resulting word appears on `rdData`.
- R5: Each bit has three phases of `PHASE_CYC` cycles: MDC low with the new data already on the line, then MDC high, then MDC low. Output data does not change while MDC rises.
- R6: In push-pull mode (`OPEN_DRAIN`=0), `mdioOe` is high for every driven bit and `mdioOut` carries the bit value, or 0 when released. In open-drain mode, `mdioOe` is high only for driven 0 bits and `mdioOut` is always 0.
- R7: `done` is high for exactly one cycle, in the cycle right after the last phase of the last frame bit. `busy` is already low in that cycle, and a new command is accepted in it.
- R8: A command presented while `busy` is high is ignored and does not disturb the running transaction.
- R9: `cmdOp` encoding: 2'b00 read, 2'b01 write, 2'b10 scan. The value 2'b11 is ignored and starts nothing.
- R10: A scan reads register 1 at PHY address 0, then 1, 2 and so on, with frames back to back. It stops at the first value that is neither 16'hFFFF nor 16'h0000. At that point `foundPhy` is that address, `rdData` is that value and `error` is 0.
- R11: If no address up to 31 qualifies, the scan ends after 32 frames with `error`=1, `foundPhy`=31 and `rdData` holding the last value read.
- R12: Completion of a read or a write clears `error`. A write leaves `rdData` and `foundPhy` unchanged, and a read leaves `foundPhy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken only while idle |
| cmdOp | input | 2 | 00 read, 01 write, 10 scan, 11 ignored |
| cmdPhy | input | 5 | PHY address for read or write |
| cmdReg | input | 5 | Register address for read or write |
| cmdWrData | input | 16 | Data for a write |
| busy | output | 1 | A transaction or scan is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last word read |
| error | output | 1 | Last scan found no PHY |
| foundPhy | output | 5 | Address where the last scan stopped |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions assume three things about the inputs. Reset is held long enough to clear the control state. `cmdValid` is a clean synchronous strobe. `mdioIn` is settled at every rising clock edge, so any metastability handling is left to the pad side. The stimulus follows this. All inputs change only on falling clock edges, and `mdioIn` stays high except during read data bits. During those bits the bench's own PHY model drives it on the exact bit schedule, and it presents 16'h0000 at one address so that the all-zeros rejection in the scan is exercised.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int HDR_BITS   = 46;   // preamble through register address
  localparam logic [4:0] STATUS_REG = 5'd1;
  localparam logic [4:0] LAST_PHY   = 5'd31;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SCAN  = 2'b10,
    OP_NONE  = 2'b11
  } mdioOp_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
    logic isWrite;
    logic isScan;
  } dpCtl_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PHASE_CYC = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [4:0]  cmdPhy,
  input  logic [4:0]  cmdReg,
  input  logic [15:0] cmdWrData,
  input  logic        respUsable,
  output dpCtl_t      ctl,
  output logic [4:0]  ldPhy,
  output logic [4:0]  ldReg,
  output logic        ldWrite,
  output logic [15:0] ldData,
  output logic [4:0]  curPhy,
  output logic        busy,
  output logic        mdc,
  output logic        drive
);

  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] CNT_LAST  = CW'(PHASE_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] BIT_HDR   = BW'(HDR_BITS);
  localparam logic [BW-1:0] BIT_DATA0 = BW'(FRAME_BITS - DATA_BITS);

  logic          runQ;
  logic [1:0]    opQ;
  logic [4:0]    phyQ;
  logic [CW-1:0] cntQ;
  logic [1:0]    phaseQ;
  logic [BW-1:0] bitQ;

  logic accept, phaseEnd, bitEnd, frameEnd, scanNext;

  always_comb begin
    accept   = cmdValid && !runQ && (cmdOp != OP_NONE);
    phaseEnd = runQ && (cntQ == CNT_LAST);
    bitEnd   = phaseEnd && (phaseQ == 2'd2);
    frameEnd = bitEnd && (bitQ == BIT_LAST);
    scanNext = frameEnd && (opQ == OP_SCAN) && !respUsable && (phyQ != LAST_PHY);
  end

  // fields of the next frame to be loaded
  always_comb begin
    if (accept) begin
      ldPhy   = (cmdOp == OP_SCAN) ? 5'd0 : cmdPhy;
      ldReg   = (cmdOp == OP_SCAN) ? STATUS_REG : cmdReg;
      ldWrite = (cmdOp == OP_WRITE);
      ldData  = cmdWrData;
    end else begin
      ldPhy   = phyQ + 5'd1;
      ldReg   = STATUS_REG;
      ldWrite = 1'b0;
      ldData  = '0;
    end
  end

  always_comb begin
    ctl.load    = accept || scanNext;
    ctl.shift   = bitEnd && !frameEnd;
    ctl.sample  = phaseEnd && (phaseQ == 2'd1) && (opQ != OP_WRITE) && (bitQ >= BIT_DATA0);
    ctl.finish  = frameEnd && !scanNext;
    ctl.isWrite = (opQ == OP_WRITE);
    ctl.isScan  = (opQ == OP_SCAN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      opQ    <= OP_READ;
      phyQ   <= '0;
      cntQ   <= '0;
      phaseQ <= '0;
      bitQ   <= '0;
    end else if (accept) begin
      runQ   <= 1'b1;
      opQ    <= cmdOp;
      phyQ   <= ldPhy;
      cntQ   <= '0;
      phaseQ <= '0;
      bitQ   <= '0;
    end else if (runQ) begin
      if (phaseEnd) begin
        cntQ <= '0;
        if (phaseQ == 2'd2) begin
          phaseQ <= '0;
          if (frameEnd) begin
            bitQ <= '0;
            if (scanNext) phyQ <= phyQ + 5'd1;
            else          runQ <= 1'b0;
          end else begin
            bitQ <= bitQ + 1'b1;
          end
        end else begin
          phaseQ <= phaseQ + 2'd1;
        end
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign curPhy = phyQ;
  assign busy   = runQ;
  assign mdc    = runQ && (phaseQ == 2'd1);
  assign drive  = runQ && ((bitQ < BIT_HDR) || (opQ == OP_WRITE));

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [4:0]  ldPhy,
  input  logic [4:0]  ldReg,
  input  logic        ldWrite,
  input  logic [15:0] ldData,
  input  logic [4:0]  curPhy,
  input  logic        drive,
  input  logic        mdioIn,
  output logic        respUsable,
  output logic        done,
  output logic [15:0] rdData,
  output logic        error,
  output logic [4:0]  foundPhy,
  output logic        mdioOut,
  output logic        mdioOe
);

  logic [FRAME_BITS-1:0] frameQ;
  logic [DATA_BITS-1:0]  rdShiftQ;
  logic                  bitNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ   <= '1;
      rdShiftQ <= '0;
      done     <= 1'b0;
      rdData   <= '0;
      error    <= 1'b0;
      foundPhy <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.load)
        frameQ <= {{PRE_BITS{1'b1}}, 2'b01, (ldWrite ? 2'b01 : 2'b10),
                   ldPhy, ldReg, 2'b10, ldData};
      else if (ctl.shift)
        frameQ <= {frameQ[FRAME_BITS-2:0], 1'b1};
      if (ctl.sample)
        rdShiftQ <= {rdShiftQ[DATA_BITS-2:0], mdioIn};
      if (ctl.finish) begin
        if (!ctl.isWrite) rdData <= rdShiftQ;
        if (ctl.isScan)   foundPhy <= curPhy;
        error <= ctl.isScan && !respUsable;
      end
    end
  end

  assign respUsable = (rdShiftQ != '0) && (rdShiftQ != '1);
  assign bitNow     = frameQ[FRAME_BITS-1];

  generate
    if (OPEN_DRAIN) begin : g_od
      assign mdioOe  = drive & ~bitNow;
      assign mdioOut = 1'b0;
    end else begin : g_pp
      assign mdioOe  = drive;
      assign mdioOut = drive & bitNow;
    end
  endgenerate

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHASE_CYC  = 17,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [4:0]  cmdPhy,
  input  logic [4:0]  cmdReg,
  input  logic [15:0] cmdWrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        error,
  output logic [4:0]  foundPhy,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  dpCtl_t      ctl;
  logic [4:0]  ldPhy, ldReg, curPhy;
  logic        ldWrite, respUsable, drive;
  logic [15:0] ldData;

  mdio_ctrl #(.PHASE_CYC(PHASE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdWrData(cmdWrData),
    .respUsable(respUsable), .ctl(ctl), .ldPhy(ldPhy), .ldReg(ldReg),
    .ldWrite(ldWrite), .ldData(ldData), .curPhy(curPhy),
    .busy(busy), .mdc(mdc), .drive(drive)
  );

  mdio_dp #(.OPEN_DRAIN(OPEN_DRAIN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ldPhy(ldPhy), .ldReg(ldReg),
    .ldWrite(ldWrite), .ldData(ldData), .curPhy(curPhy), .drive(drive),
    .mdioIn(mdioIn), .respUsable(respUsable), .done(done), .rdData(rdData),
    .error(error), .foundPhy(foundPhy), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOe) && $stable(mdioOut)));

  p_high_needs_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    mdioOut |-> mdioOe);

  p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (OPEN_DRAIN != 1'b0) |-> !mdioOut);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_on_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

endmodule

bind mdio_master mdio_master_chk #(.OPEN_DRAIN(OPEN_DRAIN)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy), .done(done),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

  localparam int P      = 3;
  localparam int BITC   = 3 * P;
  localparam int FRAMEC = 64 * BITC;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, cmdValid, mdioIn;
  logic [1:0]  cmdOp;
  logic [4:0]  cmdPhy, cmdReg;
  logic [15:0] cmdWrData;

  logic        busy, done, error, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic [4:0]  foundPhy;
  logic        busyO, doneO, errorO, mdcO, mdioOutO, mdioOeO;
  logic [15:0] rdDataO;
  logic [4:0]  foundPhyO;

  mdio_master #(.PHASE_CYC(P), .OPEN_DRAIN(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdWrData(cmdWrData),
    .busy(busy), .done(done), .rdData(rdData), .error(error),
    .foundPhy(foundPhy), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  mdio_master #(.PHASE_CYC(P), .OPEN_DRAIN(1'b1)) u_dut_od (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdWrData(cmdWrData),
    .busy(busyO), .done(doneO), .rdData(rdDataO), .error(errorO),
    .foundPhy(foundPhyO), .mdc(mdcO), .mdioOut(mdioOutO), .mdioOe(mdioOeO),
    .mdioIn(mdioIn)
  );

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;
  int respAddr   = 5;

  logic [15:0] expRd    = '0;
  logic        expErr   = 1'b0;
  logic [4:0]  expFound = '0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // PHY model: one live PHY, address 2 answers all zeros, the rest float high
  function automatic logic [15:0] phyResp(input int a, input int r);
    logic [4:0] a5 = a[4:0];
    logic [4:0] r5 = r[4:0];
    if (a == respAddr) return {3'b101, a5, 3'b011, r5};
    if (a == 2)        return 16'h0000;
    return 16'hFFFF;
  endfunction

  function automatic logic expBit(input int i, input logic wr, input logic [4:0] phy,
                                  input logic [4:0] rg, input logic [15:0] wd);
    if (i < 32)  return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return ~wr;
    if (i == 35) return wr;
    if (i < 41)  return phy[40 - i];
    if (i < 46)  return rg[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return wd[63 - i];
  endfunction

  task automatic runTxn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input bit poke);
    logic        wr;
    logic [15:0] lastV;
    logic [4:0]  lastP;
    bit          ok;
    wr = (op == 2'b01);
    ok = 1'b0;
    lastV = '0;
    lastP = '0;
    @(negedge clk);
    cmdOp = op; cmdPhy = phy; cmdReg = rg; cmdWrData = wd; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int j = 0; j < 32; j++) begin
      logic [4:0]  fp;
      logic [4:0]  fr;
      logic [15:0] v;
      fp = (op == 2'b10) ? j[4:0] : phy;
      fr = (op == 2'b10) ? 5'd1 : rg;
      v  = phyResp(int'(fp), int'(fr));
      for (int k = 0; k < FRAMEC; k++) begin
        int   i;
        int   ph;
        logic drv;
        logic b;
        i   = k / BITC;
        ph  = (k / P) % 3;
        drv = (i < 46) || wr;
        b   = expBit(i, wr, fp, fr, wd);
        mdioIn = (!wr && i >= 48) ? v[63 - i] : 1'b1;
        if (poke && j == 0 && k == 5) begin
          cmdValid = 1'b1; cmdOp = 2'b01; cmdPhy = ~phy; cmdWrData = ~wd;  // R8
        end else begin
          cmdValid = 1'b0;
        end
        chk(mdc,  ph == 1, "R5 mdc phase");
        chk(mdcO, ph == 1, "R5 mdc phase od");
        chk(mdioOe,  drv, "R2 drive enable");
        chk(mdioOut, drv & b, "R3 bit value");
        chk(mdioOeO,  drv & ~b, "R6 od enable");
        chk(mdioOutO, 1'b0, "R6 od value");
        chk(busy, 1'b1, "R8 busy held");
        chk(done, 1'b0, "R7 no early done");
        @(negedge clk);
      end
      lastV = v;
      lastP = fp;
      if (op != 2'b10) break;
      if (v != 16'hFFFF && v != 16'h0000) begin ok = 1'b1; break; end
    end
    mdioIn = 1'b1;
    chk(done,  1'b1, "R7 done pulse");
    chk(doneO, 1'b1, "R7 done pulse od");
    chk(busy,  1'b0, "R7 busy low at done");
    chk(mdioOe, 1'b0, "R3 released after frame");
    if (op == 2'b00) begin expRd = lastV; expErr = 1'b0; end
    else if (op == 2'b01) expErr = 1'b0;
    else begin expRd = lastV; expErr = ~ok; expFound = lastP; end
    chk(rdData, expRd, "R4 read data");
    chk(rdDataO, expRd, "R4 read data od");
    chk(error, expErr, "R11 error flag");
    chk(foundPhy, expFound, "R10 found address");
    @(negedge clk);
    chk(done, 1'b0, "R7 single cycle");
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'b00; cmdPhy = '0; cmdReg = '0;
    cmdWrData = '0; mdioIn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy, 1'b0, "R1 busy");
    chk(done, 1'b0, "R1 done");
    chk(mdc, 1'b0, "R1 mdc");
    chk(mdioOe, 1'b0, "R1 oe");
    chk(rdData, 16'h0, "R1 rdData");
    chk(error, 1'b0, "R1 error");
    chk(foundPhy, 5'd0, "R1 foundPhy");

    runTxn(2'b01, 5'd5, 5'd4, 16'hA5C3, 1'b1);   // R3 write, R8 poke
    runTxn(2'b00, 5'd5, 5'd2, 16'h0, 1'b1);      // R4 read, R8 poke
    runTxn(2'b00, 5'd7, 5'd3, 16'h0, 1'b0);      // R4 floating bus
    runTxn(2'b01, 5'd18, 5'd27, 16'h0001, 1'b0); // R12 write keeps rdData

    // R9 reserved opcode starts nothing
    @(negedge clk);
    cmdOp = 2'b11; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int n = 0; n < 20; n++) begin
      chk(busy, 1'b0, "R9 reserved op ignored");
      chk(mdioOe, 1'b0, "R9 bus quiet");
      chk(done, 1'b0, "R9 no done");
      @(negedge clk);
    end

    respAddr = 5;
    runTxn(2'b10, 5'd0, 5'd0, 16'h0, 1'b0);      // R10 scan skips zero at 2
    respAddr = 0;
    runTxn(2'b10, 5'd9, 5'd9, 16'h0, 1'b0);      // R10 first address
    respAddr = -1;
    runTxn(2'b10, 5'd0, 5'd0, 16'h0, 1'b0);      // R11 nothing found
    chk(errorO, 1'b1, "R11 error od");
    respAddr = 12;
    runTxn(2'b00, 5'd12, 5'd1, 16'h0, 1'b0);     // R12 read clears error
    chk(error, 1'b0, "R12 error cleared");
    chk(foundPhy, 5'd31, "R12 foundPhy kept");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule